// File: doc/BRIEF.md
# Message-Signalled Interrupt Receiver

This block is a write-only message target. A device raises an interrupt by writing anywhere inside the block's address window. The block routes the interrupt using only the address of that write. It adds a fixed window base to the port offset. It then reads a CPU number and a vector number out of the full address, and it sets that vector's bit in the selected CPU's 256-entry pending set. Each pending bit stays set until software clears it.

Each CPU has its own interrupt line. That line is high while any bit in the CPU's pending set is high. Software acknowledges one vector at a time through that CPU's clear port. The register port accepts one request per cycle. It answers every request, read or write, in the following cycle. Reads always return zero, and the window is little-endian.

Top module: `msgirq_rx`

## Requirements
- R1: While `rst_n` is low, `irq_o`, `rsp_valid` and `req_ready` are all 0. From the first cycle after reset is released, `req_ready` is 1.
- R2: The destination CPU is bits 19:12 of the full address (`WIN_BASE` + `req_addr`). An accepted write raises the `irq_o` bit of that CPU and of no other CPU.
- R3: The vector is bits 11:4 of the full address. The write sets exactly that pending bit, so a clear of that vector (index on `clr_vec[8c+7:8c]`) drops the line and a clear of any other vector does not.
- R4: Address bits 3:0 and 27:20, `req_wdata` and `req_strb` have no effect on routing. The fixed window field in bits 39:28 comes from `WIN_BASE` and has no effect on routing either.
- R5: Every accepted request gives `rsp_valid` = 1 for exactly one cycle, in the cycle after acceptance. `rsp_valid` is 0 in any cycle that does not follow an acceptance.
- R6: A read (`req_write` = 0) completes with `rsp_rdata` = 0 and changes no pending bit.
- R7: Pending bits are sticky. Writing the same vector again leaves its bit set, and a single clear then removes it. A line never falls unless a clear was applied to it.
- R8: A CPU's `irq_o` bit is the OR of its pending bits. It stays high until every set vector has been cleared.
- R9: A write whose CPU number is N_CPU or higher completes normally (R5) and changes no pending bit and no `irq_o`.
- R10: When a write sets a bit and a clear targets the same bit in the same cycle, the bit ends up set.
- R11: A clear of a vector that is not pending leaves the other pending bits and the line unchanged.
- R12: The block accepts back-to-back writes in consecutive cycles. `irq_o` reflects each write in the cycle after that write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write (message), 0 = read |
| req_addr | input | OFS_W | Byte offset inside the window |
| req_wdata | input | 32 | Write data, ignored |
| req_strb | input | 4 | Byte strobes, ignored |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_rdata | output | 32 | Read data, always zero |
| clr_valid | input | N_CPU | Per-CPU clear strobe |
| clr_vec | input | N_CPU*8 | Per-CPU vector index to clear, packed 8 bits per CPU |
| irq_o | output | N_CPU | Per-CPU interrupt line |

## Verification
Two situations are hard to reach from the ports. The first is a set and a clear that hit the same pending bit on the same clock edge. The bench reaches it by driving a clear strobe in the same cycle as the message write, and then checks that the line is still high. The second is a pending bit that a later stimulus could overwrite without any visible sign. The state of each pending bit shows only through the OR on the line, so the bench uses clears to prove the state: it clears the wrong vector first, then the right one, and checks that the line falls only on the right one. Writes with junk in the ignored address bits and in the data are also proved this way, by clearing the vector the bench expects them to have set.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;
    localparam int FULL_W = 40;
    localparam int VEC_LO = 4;
    localparam int VEC_W  = 8;
    localparam int CPU_LO = 12;
    localparam int CPU_W  = 8;
    localparam int N_VEC  = 1 << VEC_W;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic             hit;
        logic [CPU_W-1:0] cpu;
        logic [VEC_W-1:0] vec;
    } route_t;
endpackage

// File: rtl/msgirq_decode.sv
module msgirq_decode
    import msgirq_pkg::*;
#(
    parameter int            N_CPU    = 4,
    parameter int            OFS_W    = 28,
    parameter logic [39:0]   WIN_BASE = 40'h0E0_0000_0000
) (
    input  logic [OFS_W-1:0] ofs,
    output route_t           route
);
    logic [FULL_W-1:0] full_addr;
    logic              unused_addr_bits;

    always_comb begin
        full_addr = WIN_BASE + FULL_W'(ofs);
        route.cpu = full_addr[CPU_LO +: CPU_W];
        route.vec = full_addr[VEC_LO +: VEC_W];
        route.hit = (32'(route.cpu) < N_CPU);
    end

    assign unused_addr_bits = ^{full_addr[FULL_W-1:CPU_LO+CPU_W], full_addr[VEC_LO-1:0]};
endmodule

// File: rtl/msgirq_port.sv
module msgirq_port
    import msgirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              wr_fire
);
    typedef struct packed {
        logic rdy;
        logic rsp;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b1;
        st_d.rsp = req_valid & st_q.rdy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = st_q.rdy;
    assign rsp_valid = st_q.rsp;
    assign rsp_rdata = '0;
    assign wr_fire   = req_valid & st_q.rdy & req_write;
endmodule

// File: rtl/msgirq_bank.sv
module msgirq_bank
    import msgirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [VEC_W-1:0] set_vec,
    input  logic             clr_en,
    input  logic [VEC_W-1:0] clr_vec,
    output logic             irq
);
    typedef struct packed {
        logic [N_VEC-1:0] pend;
        logic             line;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.pend[clr_vec] = 1'b0;
        end
        if (set_en) begin
            st_d.pend[set_vec] = 1'b1;
        end
        st_d.line = |st_d.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.line;
endmodule

// File: rtl/msgirq_rx.sv
module msgirq_rx
    import msgirq_pkg::*;
#(
    parameter int          N_CPU    = 4,
    parameter int          OFS_W    = 28,
    parameter logic [39:0] WIN_BASE = 40'h0E0_0000_0000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [OFS_W-1:0]       req_addr,
    input  logic [31:0]            req_wdata,
    input  logic [3:0]             req_strb,
    output logic                   rsp_valid,
    output logic [31:0]            rsp_rdata,
    input  logic [N_CPU-1:0]       clr_valid,
    input  logic [N_CPU*VEC_W-1:0] clr_vec,
    output logic [N_CPU-1:0]       irq_o
);
    route_t route;
    logic   wr_fire;
    logic   unused_payload;

    assign unused_payload = ^{req_wdata, req_strb};

    msgirq_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .wr_fire   (wr_fire)
    );

    msgirq_decode #(
        .N_CPU    (N_CPU),
        .OFS_W    (OFS_W),
        .WIN_BASE (WIN_BASE)
    ) u_decode (
        .ofs   (req_addr),
        .route (route)
    );

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        logic sel;
        assign sel = wr_fire & route.hit & (32'(route.cpu) == c);

        msgirq_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (sel),
            .set_vec (route.vec),
            .clr_en  (clr_valid[c]),
            .clr_vec (clr_vec[c*VEC_W +: VEC_W]),
            .irq     (irq_o[c])
        );
    end
endmodule

// File: rtl/msgirq_rx_chk.sv
module msgirq_rx_chk #(
    parameter int N_CPU = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic             rsp_valid,
    input logic [N_CPU-1:0] clr_valid,
    input logic [N_CPU-1:0] irq_o
);
    logic accept;
    assign accept = req_valid & req_ready;

    p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> req_ready);

    p_rsp_follows_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);

    p_no_stray_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid);

    for (genvar c = 0; c < N_CPU; c++) begin : g_line
        p_rise_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[c]) |-> $past(accept & req_write));

        p_line_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o[c] && !clr_valid[c]) |=> irq_o[c]);

        p_fall_needs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_o[c]) |-> $past(clr_valid[c]));
    end
endmodule

bind msgirq_rx msgirq_rx_chk #(.N_CPU(N_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .clr_valid (clr_valid),
    .irq_o     (irq_o)
);

// File: tb/msgirq_rx_bench.sv
module msgirq_rx_bench;
    localparam int          NC    = 4;
    localparam int          OW    = 28;
    localparam logic [39:0] BASE  = 40'h0E0_0000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [OW-1:0]   req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic [3:0]      req_strb = '0;
    logic            rsp_valid;
    logic [31:0]     rsp_rdata;
    logic [NC-1:0]   clr_valid = '0;
    logic [NC*8-1:0] clr_vec = '0;
    logic [NC-1:0]   irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    msgirq_rx #(.N_CPU(NC), .OFS_W(OW), .WIN_BASE(BASE)) u_msgirq_rx (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .clr_valid(clr_valid), .clr_vec(clr_vec), .irq_o(irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [OW-1:0] mk_ofs(int cpu, int vec, logic [3:0] lo, logic [7:0] hi);
        logic [OW-1:0] o;
        o = '0;
        o[27:20] = hi;
        o[19:12] = 8'(cpu);
        o[11:4]  = 8'(vec);
        o[3:0]   = lo;
        return o;
    endfunction

    function automatic logic [NC-1:0] exp_line(logic [OW-1:0] o);
        logic [39:0] full;
        full = BASE + 40'(o);
        if (int'(full[19:12]) < NC) return NC'(1) << full[19:12];
        return '0;
    endfunction

    // one write; returns at the negedge after acceptance
    task automatic send(logic wr, logic [OW-1:0] o, logic [31:0] d, logic [3:0] s);
        req_valid = 1'b1; req_write = wr; req_addr = o; req_wdata = d; req_strb = s;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic clear(int cpu, int vec);
        clr_valid[cpu] = 1'b1;
        clr_vec[cpu*8 +: 8] = 8'(vec);
        @(negedge clk);
        clr_valid = '0;
    endtask

    task automatic t_reset();
        check("R1 irq in reset", 32'(irq_o), 32'h0);
        check("R1 rsp in reset", 32'(rsp_valid), 32'h0);
        check("R1 ready in reset", 32'(req_ready), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", 32'(req_ready), 32'h1);
    endtask

    task automatic t_route();
        for (int c = 0; c < NC; c++) begin
            logic [OW-1:0] o;
            int v;
            v = (16 + c * 37) % 256;
            o = mk_ofs(c, v, 4'h0, 8'h00);
            send(1'b1, o, 32'h0, 4'hF);
            check("R2 R12 line routing", 32'(irq_o), 32'(exp_line(o)));
            check("R5 rsp valid", 32'(rsp_valid), 32'h1);
            check("R5 rdata zero on write", rsp_rdata, 32'h0);
            @(negedge clk);
            check("R5 single-cycle rsp", 32'(rsp_valid), 32'h0);
            clear(c, (v + 1) % 256);
            check("R3 wrong vector keeps line", 32'(irq_o), 32'(exp_line(o)));
            clear(c, v);
            check("R3 own vector drops line", 32'(irq_o), 32'h0);
        end
    endtask

    task automatic t_ignored();
        logic [OW-1:0] o;
        o = mk_ofs(1, 255, 4'hB, 8'hA5);
        send(1'b1, o, 32'hDEAD_BEEF, 4'h0);
        check("R4 junk bits ignored", 32'(irq_o), 32'h2);
        clear(1, 255);
        check("R4 vector 255 set", 32'(irq_o), 32'h0);
        o = mk_ofs(2, 0, 4'h7, 8'hFF);
        send(1'b1, o, 32'h1234_5678, 4'h5);
        check("R4 vector 0 routed", 32'(irq_o), 32'h4);
        clear(2, 0);
        check("R4 vector 0 cleared", 32'(irq_o), 32'h0);
    endtask

    task automatic t_read();
        send(1'b0, mk_ofs(0, 3, 4'h0, 8'h00), 32'h0, 4'hF);
        check("R6 read rsp", 32'(rsp_valid), 32'h1);
        check("R6 read data zero", rsp_rdata, 32'h0);
        check("R6 read no pending", 32'(irq_o), 32'h0);
    endtask

    task automatic t_sticky();
        for (int k = 0; k < 3; k++) send(1'b1, mk_ofs(0, 5, 4'h0, 8'h00), 32'(k), 4'hF);
        check("R7 line high after repeats", 32'(irq_o), 32'h1);
        repeat (3) @(negedge clk);
        check("R7 line holds", 32'(irq_o), 32'h1);
        clear(0, 5);
        check("R7 one clear suffices", 32'(irq_o), 32'h0);
    endtask

    task automatic t_or();
        send(1'b1, mk_ofs(2, 1, 4'h0, 8'h00), 32'h0, 4'hF);
        send(1'b1, mk_ofs(2, 200, 4'h0, 8'h00), 32'h0, 4'hF);
        clear(2, 7);
        check("R11 clear of idle vector", 32'(irq_o), 32'h4);
        clear(2, 1);
        check("R8 one of two cleared", 32'(irq_o), 32'h4);
        clear(2, 200);
        check("R8 all cleared", 32'(irq_o), 32'h0);
    endtask

    task automatic t_oob();
        send(1'b1, mk_ofs(NC, 9, 4'h0, 8'h00), 32'h0, 4'hF);
        check("R9 out-of-range completes", 32'(rsp_valid), 32'h1);
        check("R9 no line", 32'(irq_o), 32'h0);
        send(1'b1, mk_ofs(255, 9, 4'h0, 8'h00), 32'h0, 4'hF);
        check("R9 cpu 255 no line", 32'(irq_o), 32'h0);
        for (int c = 0; c < NC; c++) clear(c, 9);
        check("R9 nothing pending", 32'(irq_o), 32'h0);
    endtask

    task automatic t_race();
        clr_valid[3] = 1'b1;
        clr_vec[3*8 +: 8] = 8'd9;
        send(1'b1, mk_ofs(3, 9, 4'h0, 8'h00), 32'h0, 4'hF);
        clr_valid = '0;
        check("R10 set wins", 32'(irq_o), 32'h8);
        clear(3, 9);
        check("R10 bit really set", 32'(irq_o), 32'h0);
    endtask

    task automatic t_b2b();
        req_valid = 1'b1; req_write = 1'b1; req_addr = mk_ofs(0, 40, 4'h0, 8'h00);
        @(negedge clk);
        check("R12 first write line", 32'(irq_o), 32'h1);
        check("R12 first rsp", 32'(rsp_valid), 32'h1);
        req_addr = mk_ofs(3, 41, 4'h0, 8'h00);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R12 second write line", 32'(irq_o), 32'h9);
        check("R12 second rsp", 32'(rsp_valid), 32'h1);
        clear(0, 40);
        clear(3, 41);
        check("R12 both cleared", 32'(irq_o), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_route();
        t_ignored();
        t_read();
        t_sticky();
        t_or();
        t_oob();
        t_race();
        t_b2b();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule